// File: doc/BRIEF.md
# Sleep-Mode Section Retention Controller

This block sits inside a 2M-word memory device whose array is split into four equal sections, chosen by the two most significant address bits (bits 20:19 of the word address). A 5-bit configuration word arrives over a valid/ready stream. The word says how many sections stay alive (one, two, three or four), whether they count up from section 0 or down from section 3, and whether the limit applies only while the sleep pin is low or also during normal operation. A further bit controls whether a low sleep pin may drop the device into a deep-sleep state that discards everything.

The controller drives a 4-bit mask of live sections. It also flags whether the section addressed right now may be accessed, and it reports deep sleep. A per-section flag records whether stored data can still be trusted. A section that is not live while the sleep pin is low loses its flag. Deep sleep clears every flag and also restores the configuration to its power-up defaults.

Back-pressure on the configuration stream is simple. `cfg_ready` is low for the whole of deep sleep. A word offered then is neither stored nor queued, and the sender must hold it or offer it again later. Outside deep sleep the block takes a word on every cycle where `cfg_valid` is high.

Top module: `sect_retain_ctl`

## Requirements
- R1: After reset the configuration is all zeros, which means: full size, low anchoring, limit only during sleep, deep sleep allowed. After reset `cfg_ready` is 1, `sect_live` is 4'b1111, `sect_kept` is 4'b1111 and `in_deep` is 0.
- R2: A word is stored on a rising edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is 0 whenever `in_deep` is 1, and any word offered during deep sleep has no effect on the configuration.
- R3: Configuration bits 1:0 give the number of live sections as 4 minus their value: 11 gives one, 10 gives two, 01 gives three, 00 gives four. Bit 2 = 0 counts up from section 0. Bit 2 = 1 counts down from section 3. Bit i of `sect_live` stands for section i.
- R4: With bit 3 = 0, the size limit applies only while `sleep_n` is 0. While `sleep_n` is 1, `sect_live` is 4'b1111.
- R5: With bit 3 = 1, `sect_live` follows the size limit whatever the level of `sleep_n`.
- R6: `access_ok` is 1 exactly when `sleep_n` is 1, the device is not in deep sleep, and bit `addr_sect` of `sect_live` is 1.
- R7: With bit 4 = 0, deep sleep begins on the ENTRY_CYCLES-th consecutive rising edge that samples `sleep_n` low. With bit 4 = 1, deep sleep never begins.
- R8: If `sleep_n` is sampled high before the count completes, entry is cancelled and the count starts again from zero.
- R9: Deep sleep ends on the first edge that samples `sleep_n` high. On entry the configuration returns to its defaults, so afterwards all sections are live and deep sleep is allowed again.
- R10: On every edge with `sleep_n` low, `sect_kept` loses each bit that is 0 in `sect_live`. On entry to deep sleep `sect_kept` becomes 4'b0000. A cleared bit is set again only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Configuration word can be taken |
| cfg_word | input | 5 | Configuration word (bit 4 no-deep, bit 3 always-limit, bit 2 top, bits 1:0 size) |
| sleep_n | input | 1 | Sleep pin, low requests low-power state |
| addr_sect | input | 2 | Section bits of the current access address |
| sect_live | output | 4 | Sections currently kept alive |
| access_ok | output | 1 | Current address may be accessed |
| in_deep | output | 1 | Deep sleep active |
| sect_kept | output | 4 | Per-section data-trust flags |

## Verification
The assertions take for granted that `sleep_n` and `cfg_valid` are synchronous to `clk`, and that reset is held for at least one edge before anything else is checked. The properties on the entry counter, and the one tying deep sleep to cleared trust flags, also assume that ENTRY_CYCLES is at least 1. The stimulus changes every input only at the falling edge. It offers configuration words during deep sleep on purpose to exercise the back-pressure rule, and it holds the sleep pin low for runs both shorter and longer than the entry window.

// File: rtl/sect_retain_pkg.sv
package sect_retain_pkg;
  localparam int NSECT = 4;
  localparam int SECT_W = $clog2(NSECT);

  typedef struct packed {
    logic       no_deep;
    logic       always_lim;
    logic       top;
    logic [1:0] size;
  } retain_cfg_t;

  localparam retain_cfg_t CFG_DEFAULT = '0;
endpackage

// File: rtl/sect_mask_dec.sv
module sect_mask_dec
  import sect_retain_pkg::*;
(
  input  logic [1:0]       size,
  input  logic             top,
  output logic [NSECT-1:0] mask
);
  localparam int CNT_W = $clog2(NSECT + 1);

  logic [CNT_W-1:0] live_cnt;
  assign live_cnt = CNT_W'(NSECT) - CNT_W'(size);

  for (genvar i = 0; i < NSECT; i++) begin : g_sect
    localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
    localparam logic [CNT_W-1:0] RIDX = CNT_W'(NSECT - i);
    assign mask[i] = top ? (RIDX <= live_cnt) : (IDX < live_cnt);
  end
endmodule

// File: rtl/deep_entry_timer.sv
module deep_entry_timer #(
  parameter int ENTRY_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic allow,
  output logic enter,
  output logic deep_q
);
  localparam int CW = $clog2(ENTRY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(ENTRY_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign enter = !deep_q && !sleep_n && allow && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      deep_q <= 1'b0;
    end else if (deep_q) begin
      cnt <= '0;
      if (sleep_n) deep_q <= 1'b0;
    end else if (enter) begin
      cnt    <= '0;
      deep_q <= 1'b1;
    end else if (!sleep_n && allow) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  assert_entry_needs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deep_q) |-> !$past(sleep_n));
  assert_exit_on_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_n |=> !deep_q);
  assert_no_entry_when_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow && !deep_q) |=> !deep_q);
  assert_count_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/sect_trust_track.sv
module sect_trust_track
  import sect_retain_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_n,
  input  logic             wipe,
  input  logic [NSECT-1:0] keep,
  output logic [NSECT-1:0] kept
);
  always_ff @(posedge clk) begin
    if (!rst_n)        kept <= '1;
    else if (wipe)     kept <= '0;
    else if (!sleep_n) kept <= kept & keep;
  end

  assert_never_regains_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((kept & ~$past(kept)) == '0));
endmodule

// File: rtl/sect_retain_ctl.sv
module sect_retain_ctl
  import sect_retain_pkg::*;
#(
  parameter int ENTRY_CYCLES = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [4:0]       cfg_word,
  input  logic             sleep_n,
  input  logic [SECT_W-1:0] addr_sect,
  output logic [NSECT-1:0] sect_live,
  output logic             access_ok,
  output logic             in_deep,
  output logic [NSECT-1:0] sect_kept
);
  retain_cfg_t      cfg_q;
  logic [NSECT-1:0] lim_mask;
  logic             enter;
  logic             deep_q;

  assign cfg_ready = !deep_q;
  assign in_deep   = deep_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cfg_q <= CFG_DEFAULT;
    else if (enter || deep_q)     cfg_q <= CFG_DEFAULT;
    else if (cfg_valid)           cfg_q <= retain_cfg_t'(cfg_word);
  end

  sect_mask_dec u_dec (
    .size (cfg_q.size),
    .top  (cfg_q.top),
    .mask (lim_mask)
  );

  deep_entry_timer #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_n (sleep_n),
    .allow   (!cfg_q.no_deep),
    .enter   (enter),
    .deep_q  (deep_q)
  );

  always_comb begin
    if (deep_q)                            sect_live = '0;
    else if (cfg_q.always_lim || !sleep_n) sect_live = lim_mask;
    else                                   sect_live = '1;
  end

  assign access_ok = sleep_n && sect_live[addr_sect];

  sect_trust_track u_trust (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_n (sleep_n),
    .wipe    (enter || deep_q),
    .keep    (sect_live),
    .kept    (sect_kept)
  );

  assert_deep_wipes_trust_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_deep |-> (sect_kept == '0));
  assert_cfg_defaults_on_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_deep) |-> (cfg_q == CFG_DEFAULT));
  assert_some_live_when_awake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_deep |-> ($countones(sect_live) >= 1));
  assert_ignore_word_in_deep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_deep && sleep_n) |=> (cfg_q == CFG_DEFAULT));
endmodule

// File: tb/sect_retain_ctl_test.sv
module sect_retain_ctl_test;
  localparam int N = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic [4:0] cfg_word = '0;
  logic       sleep_n = 1'b1;
  logic [1:0] addr_sect = '0;
  logic       cfg_ready, access_ok, in_deep;
  logic [3:0] sect_live, sect_kept;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sect_retain_ctl #(.ENTRY_CYCLES(N)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_word(cfg_word), .sleep_n(sleep_n), .addr_sect(addr_sect),
    .sect_live(sect_live), .access_ok(access_ok), .in_deep(in_deep),
    .sect_kept(sect_kept)
  );

  // behavioural reference state
  logic [4:0] m_cfg = '0;
  int         m_cnt = 0;
  logic       m_deep = 1'b0;
  logic [3:0] m_kept = 4'hF;

  function automatic logic [3:0] ref_mask(logic [4:0] c);
    case ({c[2], c[1:0]})
      3'b0_11: return 4'b0001;
      3'b0_10: return 4'b0011;
      3'b0_01: return 4'b0111;
      3'b1_11: return 4'b1000;
      3'b1_10: return 4'b1100;
      3'b1_01: return 4'b1110;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [3:0] ref_live();
    if (m_deep) return 4'b0000;
    if (m_cfg[3] || !sleep_n) return ref_mask(m_cfg);
    return 4'b1111;
  endfunction

  always @(posedge clk) begin
    logic [3:0] act;
    logic       ent;
    if (!rst_n) begin
      m_cfg = '0; m_cnt = 0; m_deep = 1'b0; m_kept = 4'hF;
    end else begin
      act = ref_live();
      ent = !m_deep && !sleep_n && !m_cfg[4] && (m_cnt == N - 1);
      if (ent || m_deep) m_kept = 4'b0000;
      else if (!sleep_n) m_kept = m_kept & act;
      if (m_deep) begin
        if (sleep_n) m_deep = 1'b0;
        m_cnt = 0;
      end else if (ent) begin
        m_deep = 1'b1; m_cnt = 0;
      end else if (!sleep_n && !m_cfg[4]) m_cnt++;
      else m_cnt = 0;
      if (ent || (m_deep && !ent) || (act == 4'b0000)) m_cfg = '0;
      else if (cfg_valid) m_cfg = cfg_word;
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3/R4/R5 live", 8'(sect_live), 8'(ref_live()));
      chk("R6 access", 8'(access_ok), 8'(sleep_n && ref_live()[addr_sect]));
      chk("R7 deep", 8'(in_deep), 8'(m_deep));
      chk("R2 ready", 8'(cfg_ready), 8'(!m_deep));
      chk("R10 kept", 8'(sect_kept), 8'(m_kept));
    end
  end

  task automatic adv(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic put_cfg(logic [4:0] w);
    cfg_word = w; cfg_valid = 1'b1;
    adv(1);
    cfg_valid = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    adv(3);
    rst_n = 1'b1;
    adv(1);
    // R1 reset state
    chk("R1 ready", 8'(cfg_ready), 8'h1);
    chk("R1 live", 8'(sect_live), 8'hF);
    chk("R1 kept", 8'(sect_kept), 8'hF);
    chk("R1 deep", 8'(in_deep), 8'h0);
    chk("R1 access", 8'(access_ok), 8'h1);

    // R4 sleep-only limit, bottom half, no deep
    put_cfg(5'b10010);
    chk("R4 awake full", 8'(sect_live), 8'hF);
    sleep_n = 1'b0;
    adv(1);
    chk("R4 asleep half", 8'(sect_live), 8'h3);
    chk("R10 kept half", 8'(sect_kept), 8'h3);
    chk("R6 asleep no access", 8'(access_ok), 8'h0);
    adv(3 * N);
    chk("R7 blocked by bit4", 8'(in_deep), 8'h0);
    sleep_n = 1'b1; addr_sect = 2'd3;
    adv(1);
    chk("R4 back to full", 8'(sect_live), 8'hF);
    chk("R10 stays cleared", 8'(sect_kept), 8'h3);
    chk("R6 awake access", 8'(access_ok), 8'h1);

    // R5 / R3 limit while awake
    put_cfg(5'b11111);
    chk("R5 top quarter", 8'(sect_live), 8'h8);
    chk("R6 live sect", 8'(access_ok), 8'h1);
    addr_sect = 2'd0;
    #1 chk("R6 dead sect", 8'(access_ok), 8'h0);
    put_cfg(5'b11001);
    chk("R3 low three", 8'(sect_live), 8'h7);
    put_cfg(5'b11101);
    chk("R3 high three", 8'(sect_live), 8'hE);
    put_cfg(5'b11110);
    chk("R3 high half", 8'(sect_live), 8'hC);

    // R8 cancel, R7 entry, R2 back-pressure, R9 defaults
    put_cfg(5'b01011);
    chk("R5 low quarter", 8'(sect_live), 8'h1);
    sleep_n = 1'b0; adv(N - 1);
    sleep_n = 1'b1; adv(1);
    chk("R8 cancelled", 8'(in_deep), 8'h0);
    sleep_n = 1'b0; adv(N - 1);
    chk("R8 count restarted", 8'(in_deep), 8'h0);
    adv(1);
    chk("R7 entered", 8'(in_deep), 8'h1);
    chk("R10 wiped", 8'(sect_kept), 8'h0);
    chk("R2 ready low", 8'(cfg_ready), 8'h0);
    cfg_word = 5'b11111; cfg_valid = 1'b1;
    adv(2);
    cfg_valid = 1'b0;
    sleep_n = 1'b1; adv(1);
    chk("R9 exited", 8'(in_deep), 8'h0);
    chk("R9 defaults restored", 8'(sect_live), 8'hF);
    chk("R10 still wiped", 8'(sect_kept), 8'h0);
    sleep_n = 1'b0; adv(N);
    chk("R9 deep allowed again", 8'(in_deep), 8'h1);
    sleep_n = 1'b1; adv(1);

    // mixed traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      cfg_valid = ($urandom_range(0, 9) < 3);
      cfg_word = 5'($urandom);
      addr_sect = 2'($urandom);
      if ($urandom_range(0, 9) == 0) sleep_n = ~sleep_n;
      if ($urandom_range(0, 499) == 0) begin
        rst_n = 1'b0; adv(1); rst_n = 1'b1;
      end
      adv(1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule